// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit side of a descriptor-driven DMA. Software lays out a ring of two-word descriptors in memory, each giving a buffer pointer and a control word. It programs the ring base, the base of a parallel array of status words and the ring size minus one. It then moves a produce index forward. The engine works through the ring in order as long as its own consume index differs from the produce index. For each descriptor it fetches the buffer a word at a time and hands the bytes to a MAC-side valid/ready byte stream. It then writes one status word and moves the consume index on.

A frame may be split over several descriptors; only the fragment flagged as last ends the frame on the byte stream. Interrupt causes are recorded in sticky flags: a per-descriptor done flag, a finished flag for an emptied ring, and underrun and error flags. An enable mask reduces these flags to one interrupt line. If the MAC side stops accepting bytes for longer than a programmable limit, the engine abandons the frame. It marks the stalled descriptor with an underrun status and passes over the frame's remaining fragments without sending them.

Top module: `txring_engine`

## Requirements
- R1: After reset the consume index is 0, no memory request is made, `tx_valid` is low, every interrupt flag is clear and `irq` is low.
- R2: The engine processes a descriptor only while `cons_idx` differs from `prod_idx`, in ring order. The index after `ring_last` is 0.
- R3: Descriptor i occupies two words: the buffer pointer at `ring_base + 8*i` and the control word at `ring_base + 8*i + 4`. Control bits 10:0 hold the byte count minus one. Bytes are sent least significant byte of each memory word first, starting at the byte that pointer bits 1:0 select.
- R4: `tx_last` is high on the final byte of a descriptor whose control bit 30 is set, and on no other byte.
- R5: After each descriptor a status word is written to `stat_base + 4*i`. It is 0 for a descriptor sent in full.
- R6: `cons_idx` advances only in the cycle the status write is granted by memory. While the grant is withheld the write request stays up and the index holds.
- R7: Interrupt flag bit 7 (done) is set when a descriptor completes and its control bit 31 is set; it is not set when bit 31 is clear.
- R8: Interrupt flag bit 6 (finished) is set when the consume index advances to equal the produce index.
- R9: When `tx_valid` is high and `tx_ready` low for `stall_limit` consecutive cycles, `tx_abort` pulses once. The descriptor's status is 0xA0000000 (bit 31 error, bit 29 underrun), and interrupt flags bit 4 (underrun) and bit 5 (error) are set.
- R10: After an abort, every further descriptor up to and including the one with control bit 30 set sends no bytes and gets status 0x80000000, which sets flag bit 5. The next frame is sent normally.
- R11: A `stall_limit` of 0 turns the abort off; the engine waits on `tx_ready` indefinitely.
- R12: Interrupt flags stay set until a one is written to the same bit of `int_clr`. `irq` is high exactly when some flag is set whose `int_en` bit is set.
- R13: While `tx_valid` is high and `tx_ready` low without an abort, `tx_valid` and `tx_data` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| stat_base | input | AW | Byte address of status word 0 |
| ring_last | input | IW | Number of descriptors minus one |
| prod_idx | input | IW | Produce index written by software |
| cons_idx | output | IW | Consume index |
| stall_limit | input | SW | Stall cycles before abort, 0 disables |
| int_en | input | 8 | Interrupt enable mask |
| int_clr | input | 8 | Write-one-to-clear for interrupt flags |
| int_status | output | 8 | Interrupt flags (bits 7:4 used) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte |
| tx_last | output | 1 | Last byte of a frame |
| tx_abort | output | 1 | Frame abandoned this cycle |
| tx_ready | input | 1 | MAC accepts the byte |

## Verification
The assertions check on every cycle that the byte stream holds during backpressure and that the consume index moves only on a granted status write. They also check that the index stays inside the ring, that sticky flags never drop without a clear, and that an abort always leaves the underrun flag set. Byte order and alignment, the placement of the last marker, the status values written back, the skipping of a frame's remaining fragments and the wrap of the ring can only be shown by the bench. It does this by comparing the captured stream and the memory image against hand-built descriptor layouts.

// File: rtl/txring_engine.sv
module txring_engine #(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic [AW-1:0] stat_base,
  input  logic [IW-1:0] ring_last,
  input  logic [IW-1:0] prod_idx,
  output logic [IW-1:0] cons_idx,
  input  logic [SW-1:0] stall_limit,
  input  logic [7:0]    int_en,
  input  logic [7:0]    int_clr,
  output logic [7:0]    int_status,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_abort,
  input  logic          tx_ready
);
  typedef enum logic [2:0] {S_IDLE, S_RCTL, S_RPTR, S_RDAT, S_SEND, S_WST} state_t;

  state_t        state;
  logic          pend, skip, ctl_int, ctl_last, st_err, st_under;
  logic [11:0]   rem;
  logic [AW-1:0] waddr;
  logic [1:0]    boff;
  logic [31:0]   word;
  logic [SW-1:0] stall_cnt;
  logic [3:0]    flags, flag_set;
  logic [IW-1:0] nxt_cons;
  logic          hit, wr_done, rd_state;

  assign rd_state = (state == S_RCTL) || (state == S_RPTR) || (state == S_RDAT);
  assign mem_req  = (rd_state && !pend) || (state == S_WST);
  assign mem_we   = (state == S_WST);
  assign mem_wdata = {st_err, 1'b0, st_under, 29'd0};
  assign wr_done  = mem_we && mem_gnt;
  assign nxt_cons = (cons_idx == ring_last) ? '0 : cons_idx + 1'b1;

  always_comb begin
    case (state)
      S_RCTL:  mem_addr = ring_base + AW'({cons_idx, 3'b100});
      S_RPTR:  mem_addr = ring_base + AW'({cons_idx, 3'b000});
      S_RDAT:  mem_addr = waddr;
      S_WST:   mem_addr = stat_base + AW'({cons_idx, 2'b00});
      default: mem_addr = '0;
    endcase
  end

  assign hit      = (stall_limit != '0) && (stall_cnt == stall_limit - 1'b1);
  assign tx_valid = (state == S_SEND);
  assign tx_data  = word[8*boff +: 8];
  assign tx_last  = tx_valid && (rem == 12'd1) && ctl_last;
  assign tx_abort = tx_valid && !tx_ready && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pend <= 1'b0; skip <= 1'b0; cons_idx <= '0;
      ctl_int <= 1'b0; ctl_last <= 1'b0; st_err <= 1'b0; st_under <= 1'b0;
      rem <= '0; waddr <= '0; boff <= '0; word <= '0; stall_cnt <= '0;
    end else begin
      if (rd_state && mem_req && mem_gnt) pend <= 1'b1;
      case (state)
        S_IDLE: if (cons_idx != prod_idx) state <= S_RCTL;
        S_RCTL: if (pend && mem_rvalid) begin
          pend     <= 1'b0;
          ctl_int  <= mem_rdata[31];
          ctl_last <= mem_rdata[30];
          rem      <= {1'b0, mem_rdata[10:0]} + 12'd1;
          st_under <= 1'b0;
          st_err   <= skip;
          state    <= skip ? S_WST : S_RPTR;
        end
        S_RPTR: if (pend && mem_rvalid) begin
          pend  <= 1'b0;
          waddr <= {mem_rdata[AW-1:2], 2'b00};
          boff  <= mem_rdata[1:0];
          state <= S_RDAT;
        end
        S_RDAT: if (pend && mem_rvalid) begin
          pend      <= 1'b0;
          word      <= mem_rdata;
          stall_cnt <= '0;
          state     <= S_SEND;
        end
        S_SEND: begin
          if (tx_ready) begin
            stall_cnt <= '0;
            rem       <= rem - 1'b1;
            if (rem == 12'd1) state <= S_WST;
            else if (boff == 2'd3) begin
              boff  <= 2'd0;
              waddr <= waddr + AW'(4);
              state <= S_RDAT;
            end else boff <= boff + 1'b1;
          end else if (hit) begin
            st_err   <= 1'b1;
            st_under <= 1'b1;
            skip     <= !ctl_last;
            state    <= S_WST;
          end else if (stall_limit != '0) stall_cnt <= stall_cnt + 1'b1;
        end
        S_WST: if (mem_gnt) begin
          cons_idx <= nxt_cons;
          if (ctl_last) skip <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign flag_set = {wr_done && ctl_int, wr_done && (nxt_cons == prod_idx),
                     wr_done && st_err, tx_abort};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~int_clr[7:4]) | flag_set;
  end

  assign int_status = {flags, 4'd0};
  assign irq        = |(int_status & int_en);

  a_r2_cons_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cons_idx <= ring_last);

  a_r6_cons_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cons_idx) |-> $past(mem_req && mem_we && mem_gnt));

  a_r13_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_abort) |=> (tx_valid && $stable(tx_data)));

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_status & $past(int_status & ~int_clr)) == $past(int_status & ~int_clr)));

  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> int_status[4]);

  a_r6_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_gnt) |=> (mem_req && mem_we && $stable(mem_addr)));
endmodule

// File: tb/txring_engine_tb.sv
module txring_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, IW = 4, SW = 8;
  localparam logic [31:0] SBASE = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0] prod = '0, cons;
  logic [SW-1:0] stall_limit = '0;
  logic [7:0] int_en = '0, int_clr = '0, int_status;
  logic irq, mem_req, mem_we, mem_gnt, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_last, tx_abort, tx_ready = 1'b1, blk = 1'b0;
  logic [7:0] tx_data;

  logic [31:0] mem [0:255];
  logic [7:0]  rxb [0:63];
  logic        rxl [0:63];
  int rx_n = 0, n_abort = 0, total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txring_engine #(.AW(AW), .IW(IW), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(32'h0), .stat_base(SBASE),
    .ring_last(4'd3), .prod_idx(prod), .cons_idx(cons), .stall_limit(stall_limit),
    .int_en(int_en), .int_clr(int_clr), .int_status(int_status), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_abort(tx_abort), .tx_ready(tx_ready));

  assign mem_gnt = mem_req && !(mem_we && blk);

  always @(posedge clk) begin
    mem_rvalid <= mem_req && mem_gnt && !mem_we;
    if (mem_req && mem_gnt && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (tx_valid && tx_ready && rx_n < 64) begin
      rxb[rx_n] <= tx_data; rxl[rx_n] <= tx_last; rx_n <= rx_n + 1;
    end
    if (tx_abort) n_abort <= n_abort + 1;
  end

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int idx, input [31:0] ptr, input [31:0] ctl);
    mem[idx*2]       = ptr;
    mem[idx*2 + 1]   = ctl;
    mem[SBASE/4+idx] = 32'hDEADBEEF;
  endtask

  task automatic bump();
    prod = (prod == 4'd3) ? 4'd0 : prod + 1'b1;
  endtask

  task automatic wait_cons(input [IW-1:0] tgt);
    for (int i = 0; i < 2000 && !(cons == tgt && !mem_req); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    int_clr = 8'hFF; @(negedge clk); int_clr = 8'h00; @(negedge clk);
  endtask

  task automatic chk_byte(input int k, input [7:0] b, input bit l, input string req);
    chk(rxb[k] == b, req, {24'd0, rxb[k]}, {24'd0, b});
    chk(rxl[k] == l, "R4 last flag", {31'd0, rxl[k]}, {31'd0, l});
  endtask

  task automatic t_reset();
    chk(cons == 0 && !mem_req && !tx_valid, "R1 reset idle", {cons, mem_req, tx_valid}, 0);
    chk(int_status == 0 && !irq, "R1 reset flags", {irq, int_status}, 0);
  endtask

  task automatic t_single();
    int b0 = rx_n;
    put_desc(0, 32'h200, 32'hC000_0005);
    mem[32'h200/4] = 32'h44332211; mem[32'h204/4] = 32'h88776655;
    int_en = 8'h80; bump(); wait_cons(1);
    chk(rx_n - b0 == 6, "R3 byte count", rx_n - b0, 6);
    for (int k = 0; k < 6; k++) chk_byte(b0 + k, 8'h11 * (k + 1), k == 5, "R3 byte order");
    chk(mem[SBASE/4] == 0, "R5 status ok", mem[SBASE/4], 0);
    chk(int_status == 8'hC0, "R7 R8 done and finished", int_status, 8'hC0);
    chk(irq == 1'b1, "R12 irq enabled", irq, 1);
    int_en = 8'h20; @(negedge clk);
    chk(irq == 1'b0, "R12 irq masked", irq, 0);
    clear_all();
    chk(int_status == 0 && !irq, "R12 clear", int_status, 0);
  endtask

  task automatic t_frag();
    int b0 = rx_n;
    put_desc(1, 32'h212, 32'h0000_0002);
    put_desc(2, 32'h220, 32'h4000_0001);
    mem[32'h210/4] = 32'hDDCCBBAA; mem[32'h214/4] = 32'h000000EE;
    mem[32'h220/4] = 32'h00002F1F;
    bump(); bump(); wait_cons(3);
    chk(rx_n - b0 == 5, "R3 fragment bytes", rx_n - b0, 5);
    chk_byte(b0,   8'hCC, 0, "R3 offset start");
    chk_byte(b0+1, 8'hDD, 0, "R3 offset start");
    chk_byte(b0+2, 8'hEE, 0, "R3 next word");
    chk_byte(b0+3, 8'h1F, 0, "R4 frame spans");
    chk_byte(b0+4, 8'h2F, 1, "R4 frame end");
    chk(int_status == 8'h40, "R7 no done without bit31", int_status, 8'h40);
    chk(mem[SBASE/4+1] == 0 && mem[SBASE/4+2] == 0, "R5 both status", mem[SBASE/4+1], 0);
    clear_all();
  endtask

  task automatic t_wrap();
    int b0 = rx_n;
    put_desc(3, 32'h230, 32'hC000_0000); mem[32'h230/4] = 32'h0000005A;
    put_desc(0, 32'h240, 32'hC000_0000); mem[32'h240/4] = 32'h000000A5;
    bump(); bump(); wait_cons(1);
    chk(cons == 1, "R2 wrap index", cons, 1);
    chk(rx_n - b0 == 2 && rxb[b0] == 8'h5A && rxb[b0+1] == 8'hA5, "R2 ring order",
        {rxb[b0], rxb[b0+1]}, 16'h5AA5);
    clear_all();
  endtask

  task automatic t_grant();
    put_desc(1, 32'h250, 32'h4000_0000); mem[32'h250/4] = 32'h77;
    blk = 1'b1; bump();
    repeat (30) @(negedge clk);
    chk(cons == 1, "R6 held without grant", cons, 1);
    chk(mem_req && mem_we, "R6 write pending", {mem_req, mem_we}, 2'b11);
    blk = 1'b0; wait_cons(2);
    chk(cons == 2, "R6 advance on grant", cons, 2);
    chk(mem[SBASE/4+1] == 0, "R5 granted status", mem[SBASE/4+1], 0);
    clear_all();
  endtask

  task automatic t_underrun();
    int b0 = rx_n;
    put_desc(2, 32'h260, 32'h8000_0003);
    put_desc(3, 32'h270, 32'h0000_0003);
    put_desc(0, 32'h280, 32'h4000_0003);
    stall_limit = 8'd4; tx_ready = 1'b0;
    bump(); bump(); bump(); wait_cons(1);
    chk(n_abort == 1, "R9 one abort", n_abort, 1);
    chk(rx_n == b0, "R10 no bytes", rx_n - b0, 0);
    chk(mem[SBASE/4+2] == 32'hA000_0000, "R9 underrun status", mem[SBASE/4+2], 32'hA000_0000);
    chk(mem[SBASE/4+3] == 32'h8000_0000, "R10 skipped status", mem[SBASE/4+3], 32'h8000_0000);
    chk(mem[SBASE/4+0] == 32'h8000_0000, "R10 last skipped", mem[SBASE/4+0], 32'h8000_0000);
    chk((int_status & 8'h30) == 8'h30, "R9 underrun and error flags", int_status, 8'h30);
    clear_all();
    tx_ready = 1'b1;
    put_desc(1, 32'h290, 32'h4000_0002); mem[32'h290/4] = 32'h00635241;
    bump(); wait_cons(2);
    chk(rx_n - b0 == 3 && rxb[b0+2] == 8'h63 && rxl[b0+2], "R10 next frame normal",
        {rx_n - b0}, 3);
    chk(mem[SBASE/4+1] == 0, "R10 next status", mem[SBASE/4+1], 0);
    clear_all();
  endtask

  task automatic t_nolimit();
    int b0 = rx_n;
    logic [7:0] d0;
    put_desc(2, 32'h2A0, 32'h4000_0001); mem[32'h2A0/4] = 32'h0000BCAB;
    stall_limit = '0; tx_ready = 1'b0; bump();
    repeat (20) @(negedge clk);
    d0 = tx_data;
    repeat (40) @(negedge clk);
    chk(tx_valid && tx_data == d0, "R13 hold data", {tx_valid, tx_data}, {1'b1, d0});
    chk(n_abort == 1 && cons == 2, "R11 no abort", n_abort, 1);
    tx_ready = 1'b1; wait_cons(3);
    chk(rx_n - b0 == 2 && rxb[b0] == 8'hAB && rxb[b0+1] == 8'hBC, "R11 completes",
        {rxb[b0], rxb[b0+1]}, 16'hABBC);
    chk(mem[SBASE/4+2] == 0, "R11 status ok", mem[SBASE/4+2], 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_frag();
    t_wrap();
    t_grant();
    t_underrun();
    t_nolimit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule